// File: doc/BRIEF.md
# Buffered Bipolar Serial Word Transmitter

This block drives one transmit channel of a two-wire, return-to-zero avionics data link. A host loads 32-bit words into an internal buffer as two 16-bit halves. Nothing goes out on the line until the host issues a send command. The block then waits for its enable input and an optional start delay. After that it shifts the buffered words out one bit at a time as short pulses on a "one" line or a "zero" line, which an external line driver turns into the differential signal. Between words it keeps both lines low for a programmable gap, and that gap is never shorter than four bit times.

A control word, writable only while the channel is idle, selects the channel's settings. It chooses between sending the frame once and repeating it, between odd and even parity, and it sets the word gap and the start delay, both counted in bit times. The hardware always writes the parity bit into the last bit of each word. In repeat mode the frame goes out again and again until an active-low stop input is pulsed. The channel then completes the word it is sending and that word's gap, and discards the frame.

The controller is a five-state machine:
- IDLE waits for a send command.
- WAIT_EN waits for the enable.
- DELAY counts the start delay.
- SHIFT serialises one word.
- GAP counts the idle gap.

Its transitions are:
- ACCEPT: IDLE→WAIT_EN, on a send command while the buffer holds data.
- NODELAY: WAIT_EN→SHIFT, when enabled and the delay is zero.
- ENABLE: WAIT_EN→DELAY, when enabled and the delay is non-zero.
- DELAY_DONE: DELAY→SHIFT.
- WORD_DONE: SHIFT→GAP.
- NEXT: GAP→SHIFT, while words remain or repetition continues.
- FINISH: GAP→IDLE.

Top module: `bipolar_word_tx`

## Requirements
- R1: After reset both lines are low, `status` is 3'b001 (busy=0, full=0, empty=1), `fifo_full` is 0 and `data_rdy_n` is 0.
- R2: A write with `wr_hi`=0 holds a low half. A following write with `wr_hi`=1 stores the word {high half, low half}. A high-half write with no low half pending stores nothing.
- R3: With DEPTH words buffered, `fifo_full` and `status[1]` are 1, and further words are discarded. Full and empty are never both set.
- R4: `send_cmd` is accepted only in IDLE with a non-empty buffer. At acceptance `status[2]` (busy) rises on that edge. A send command given while the buffer is empty has no effect.
- R5: After acceptance, nothing is transmitted while `tx_en_n` is high, and busy stays 1.
- R6: With `tx_en_n` already low and a delay field D, the first bit pulse begins on the (D·BIT_CLKS+1)-th clock edge after the edge that accepts the send.
- R7: Word bit 0 goes out first and bit 31 last. Each bit lasts BIT_CLKS cycles. A 1 drives `line_hi` and a 0 drives `line_lo`, for the first BIT_CLKS/2 cycles only, and both lines are low for the rest of the bit. The two lines are never high together.
- R8: Bit 31 on the line is parity, replacing the host's bit 31. With `cfg_data[1]`=0 the 32 bits have an odd number of ones, and with 1 they have an even number.
- R9: Consecutive word starts are (32+G)·BIT_CLKS cycles apart, where G = max(4, `cfg_data[7:2]`). The start delay D is `cfg_data[15:8]`.
- R10: With `cfg_data[0]`=0, exactly the words buffered at acceptance are sent, once each and in write order. Each is removed from the buffer, and the channel then returns to IDLE.
- R11: With `cfg_data[0]`=1, the buffered frame repeats in order until `stop_n` is sampled low. The word being sent and its gap then complete, the frame is removed and the channel returns to IDLE.
- R12: Control writes are applied only in IDLE. A write made while busy changes nothing.
- R13: The lines stay low whenever busy is 0. `data_rdy_n` is 0 exactly when the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host half-word write strobe |
| wr_hi | input | 1 | 0: low half, 1: high half (completes the word) |
| wr_data | input | 16 | Half-word data |
| cfg_we | input | 1 | Control word write strobe |
| cfg_data | input | 16 | [0] repeat, [1] even parity, [7:2] gap bits, [15:8] start delay bits |
| send_cmd | input | 1 | Start transmission of the buffered frame |
| tx_en_n | input | 1 | Active-low transmit enable |
| stop_n | input | 1 | Active-low stop request for repeat mode |
| line_hi | output | 1 | Pulse line for a 1 bit |
| line_lo | output | 1 | Pulse line for a 0 bit |
| status | output | 3 | {busy, full, empty} |
| data_rdy_n | output | 1 | Low when no unsent data is buffered |
| fifo_full | output | 1 | High when the buffer is full |

## Verification
The hardest condition to reach from the ports is a stop arriving in repeat mode. The frame has to wrap at least twice, and the stop must land inside a particular word, so that the expected count of words on the line is exact. The bench decodes pulses from the line continuously. It drives the stop one cycle after the fifth decoded word appears, then expects exactly five alternating words and an empty buffer. The other hard cases are a full buffer receiving an extra word, and a control write made in the middle of a frame. Directed tests reach both of these. Random frames with random gaps, delays and parity cover the spacing arithmetic.

// File: rtl/bwtx_pkg.sv
package bwtx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_EN,
        ST_DELAY,
        ST_SHIFT,
        ST_GAP
    } tx_state_t;

    // Field layout matches cfg_data: [15:8] delay, [7:2] gap, [1] even, [0] repeat
    typedef struct packed {
        logic [7:0] delay_bits;
        logic [5:0] gap_bits;
        logic       even_par;
        logic       auto_rep;
    } tx_cfg_t;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned HALF_W  = 16;
    localparam int unsigned MIN_GAP = 4;

    // Overwrite bit 31 with the parity bit for the chosen sense
    function automatic logic [WORD_W-1:0] seal_parity(input logic [WORD_W-1:0] w,
                                                      input logic even);
        logic ones_odd;
        ones_odd = ^w[WORD_W-2:0];
        return {(even ? ones_odd : ~ones_odd), w[WORD_W-2:0]};
    endfunction

endpackage

// File: rtl/bwtx_half_pack.sv
module bwtx_half_pack #(
    parameter int unsigned HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_hi,
    input  logic [HW-1:0]   wr_data,
    output logic            push,
    output logic [2*HW-1:0] push_word
);
    logic [HW-1:0] lo_q;
    logic          lo_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q     <= '0;
            lo_valid <= 1'b0;
        end else if (wr_en) begin
            if (!wr_hi) begin
                lo_q     <= wr_data;
                lo_valid <= 1'b1;
            end else begin
                lo_valid <= 1'b0;
            end
        end
    end

    assign push      = wr_en && wr_hi && lo_valid;
    assign push_word = {wr_data, lo_q};

endmodule

// File: rtl/bwtx_fifo.sv
module bwtx_fifo #(
    parameter  int unsigned DEPTH = 8,
    parameter  int unsigned W     = 32,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic [AW-1:0] peek_ofs,
    input  logic          drop,
    input  logic [CW-1:0] drop_n,
    output logic [W-1:0]  peek_data,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] head, tail;
    logic          accept;
    logic [AW-1:0] peek_idx;

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign accept   = push && !full;
    assign peek_idx = head + peek_ofs;
    assign peek_data = mem[peek_idx];

    always_ff @(posedge clk) begin
        if (accept) mem[tail] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (accept) tail <= tail + 1'b1;
            if (drop)   head <= head + drop_n[AW-1:0];
            count <= count + CW'(accept) - (drop ? drop_n : '0);
        end
    end

endmodule

// File: rtl/bipolar_word_tx.sv
module bipolar_word_tx
    import bwtx_pkg::*;
#(
    parameter int unsigned DEPTH    = 8,
    parameter int unsigned BIT_CLKS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_hi,
    input  logic [15:0] wr_data,
    input  logic        cfg_we,
    input  logic [15:0] cfg_data,
    input  logic        send_cmd,
    input  logic        tx_en_n,
    input  logic        stop_n,
    output logic        line_hi,
    output logic        line_lo,
    output logic [2:0]  status,
    output logic        data_rdy_n,
    output logic        fifo_full
);
    localparam int unsigned AW   = $clog2(DEPTH);
    localparam int unsigned CW   = AW + 1;
    localparam int unsigned PW   = $clog2(BIT_CLKS);
    localparam int unsigned HALF = BIT_CLKS / 2;
    localparam int unsigned TW   = $clog2(256 * BIT_CLKS) + 1;
    localparam logic [TW-1:0] BITS_T = TW'(BIT_CLKS);

    tx_state_t         state, state_nxt;
    tx_cfg_t           cfg_q;
    logic [TW-1:0]     tmr;
    logic [PW-1:0]     phase;
    logic [4:0]        bit_cnt;
    logic [WORD_W-1:0] shreg;
    logic [AW-1:0]     word_idx;
    logic [CW-1:0]     frame_len, remain;
    logic              stop_pend;

    logic              push;
    logic [WORD_W-1:0] push_word, peek_data;
    logic [CW-1:0]     count;
    logic              empty, full;
    logic              drop;
    logic [CW-1:0]     drop_n;

    bwtx_half_pack #(.HW(HALF_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi),
        .wr_data(wr_data), .push(push), .push_word(push_word)
    );

    bwtx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_word),
        .peek_ofs(word_idx), .drop(drop), .drop_n(drop_n),
        .peek_data(peek_data), .count(count), .empty(empty), .full(full)
    );

    // Timing decodes
    logic [5:0]    gap_eff;
    logic [TW-1:0] gap_lim, delay_lim;
    logic          phase_last, word_end, delay_done, gap_done, more, enter_shift;

    assign gap_eff    = (cfg_q.gap_bits < 6'(MIN_GAP)) ? 6'(MIN_GAP) : cfg_q.gap_bits;
    assign gap_lim    = TW'(gap_eff) * BITS_T;
    assign delay_lim  = TW'(cfg_q.delay_bits) * BITS_T;
    assign phase_last = (phase == PW'(BIT_CLKS - 1));
    assign word_end   = (state == ST_SHIFT) && phase_last && (bit_cnt == 5'd31);
    assign delay_done = (tmr == delay_lim - 1'b1);
    assign gap_done   = (tmr == gap_lim - 1'b1);
    assign more       = cfg_q.auto_rep ? !stop_pend : (remain != '0);

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (send_cmd && !empty) state_nxt = ST_WAIT_EN;      // ACCEPT
            ST_WAIT_EN: if (!tx_en_n)
                            state_nxt = (cfg_q.delay_bits == '0) ? ST_SHIFT   // NODELAY
                                                                  : ST_DELAY; // ENABLE
            ST_DELAY:   if (delay_done) state_nxt = ST_SHIFT;                // DELAY_DONE
            ST_SHIFT:   if (word_end) state_nxt = ST_GAP;                    // WORD_DONE
            ST_GAP:     if (gap_done) state_nxt = more ? ST_SHIFT            // NEXT
                                                       : ST_IDLE;            // FINISH
            default:    state_nxt = ST_IDLE;
        endcase
    end

    assign enter_shift = (state_nxt == ST_SHIFT) && (state != ST_SHIFT);

    // Buffer release: one word per word in single mode, the whole frame on stop
    assign drop   = (word_end && !cfg_q.auto_rep) ||
                    ((state == ST_GAP) && gap_done && cfg_q.auto_rep && stop_pend);
    assign drop_n = cfg_q.auto_rep ? frame_len : CW'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '{delay_bits: 8'd0, gap_bits: 6'(MIN_GAP), even_par: 1'b0, auto_rep: 1'b0};
            tmr       <= '0;
            phase     <= '0;
            bit_cnt   <= '0;
            shreg     <= '0;
            word_idx  <= '0;
            frame_len <= '0;
            remain    <= '0;
            stop_pend <= 1'b0;
        end else begin
            if (state == ST_IDLE && cfg_we)
                cfg_q <= tx_cfg_t'(cfg_data);

            if (state == ST_IDLE && state_nxt == ST_WAIT_EN) begin
                frame_len <= count;
                remain    <= count;
                word_idx  <= '0;
                stop_pend <= 1'b0;
            end else if (state != ST_IDLE && cfg_q.auto_rep && !stop_n) begin
                stop_pend <= 1'b1;
            end

            if (state_nxt != state)
                tmr <= '0;
            else if (state == ST_DELAY || state == ST_GAP)
                tmr <= tmr + 1'b1;

            if (enter_shift) begin
                shreg   <= seal_parity(peek_data, cfg_q.even_par);
                phase   <= '0;
                bit_cnt <= '0;
            end else if (state == ST_SHIFT) begin
                phase <= phase_last ? '0 : phase + 1'b1;
                if (phase_last) begin
                    shreg   <= shreg >> 1;
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end

            if (word_end) begin
                if (!cfg_q.auto_rep)
                    remain <= remain - 1'b1;
                else
                    word_idx <= ({1'b0, word_idx} == frame_len - 1'b1) ? '0 : word_idx + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        logic pulse;
        pulse      = (state == ST_SHIFT) && (phase < PW'(HALF));
        line_hi    = pulse && shreg[0];
        line_lo    = pulse && !shreg[0];
        status     = {(state != ST_IDLE), full, empty};
        data_rdy_n = !empty;
        fifo_full  = full;
    end

endmodule

// File: rtl/bwtx_checker.sv
module bwtx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        line_hi,
    input logic        line_lo,
    input logic [2:0]  status,
    input logic        send_cmd,
    input logic [15:0] cfg_word
);
    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_hi && line_lo));

    assert_quiet_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !status[2] |-> (!line_hi && !line_lo));

    assert_full_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[1] && status[0]));

    assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> ($past(send_cmd) && !$past(status[0])));

    assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && $past(status[2])) |-> $stable(cfg_word));

endmodule

bind bipolar_word_tx bwtx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .line_hi(line_hi), .line_lo(line_lo),
    .status(status), .send_cmd(send_cmd), .cfg_word(cfg_q)
);

// File: tb/bipolar_word_tx_bench.sv
module bipolar_word_tx_bench;
    localparam int DEPTH = 8;
    localparam int B     = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 0, wr_hi = 0, cfg_we = 0, send_cmd = 0, tx_en_n = 0, stop_n = 1;
    logic [15:0] wr_data = '0, cfg_data = '0;
    logic line_hi, line_lo, data_rdy_n, fifo_full;
    logic [2:0] status;

    bipolar_word_tx #(.DEPTH(DEPTH), .BIT_CLKS(B)) u_bipolar_word_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
        .cfg_we(cfg_we), .cfg_data(cfg_data), .send_cmd(send_cmd), .tx_en_n(tx_en_n),
        .stop_n(stop_n), .line_hi(line_hi), .line_lo(line_lo), .status(status),
        .data_rdy_n(data_rdy_n), .fifo_full(fifo_full)
    );

    always #5 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0, send_cyc = 0, bad_width = 0;
    bit done = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Line monitor: decodes pulses into words
    logic [31:0] dq[$];
    int          ds[$];
    logic [31:0] acc;
    int nb = 0, width = 0, wstart = 0;
    bit prev_act = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if ((line_hi || line_lo) && !prev_act) begin
                if (nb == 0) wstart = cyc;
                acc[nb] = line_hi;
                nb++;
                width = 1;
                if (nb == 32) begin
                    dq.push_back(acc);
                    ds.push_back(wstart);
                    nb = 0;
                end
            end else if (line_hi || line_lo) begin
                width++;
            end else if (prev_act && width != B / 2) begin
                bad_width++;
            end
            prev_act = line_hi || line_lo;
        end
    end

    function automatic logic [31:0] exp_word(input logic [31:0] w, input bit even);
        logic p;
        p = ^w[30:0];
        return {(even ? p : ~p), w[30:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_half(input bit hi, input logic [15:0] d);
        @(negedge clk); wr_en = 1; wr_hi = hi; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic write_word(input logic [31:0] w);
        write_half(0, w[15:0]);
        write_half(1, w[31:16]);
    endtask

    task automatic set_cfg(input bit rep, input bit even, input int gap, input int dly);
        @(negedge clk); cfg_we = 1; cfg_data = {dly[7:0], gap[5:0], even, rep};
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic send();
        @(negedge clk); send_cmd = 1; send_cyc = cyc;
        @(negedge clk); send_cmd = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40000 && status[2]; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Single-frame run with full decode checks
    task automatic run_single(input int n, input bit even, input int gap, input int dly);
        logic [31:0] words[$];
        int geff;
        geff = (gap < 4) ? 4 : gap;
        dq.delete(); ds.delete();
        set_cfg(0, even, gap, dly);
        for (int i = 0; i < n; i++) begin
            words.push_back($urandom());
            write_word(words[i]);
        end
        send();
        wait_idle();
        chk(dq.size() == n, "R10 word count", dq.size(), n);
        for (int i = 0; i < n && i < dq.size(); i++) begin
            chk(dq[i] == exp_word(words[i], even), "R8 R7 word content", dq[i], exp_word(words[i], even));
            if (i > 0)
                chk(ds[i] - ds[i-1] == (32 + geff) * B, "R9 word spacing", ds[i] - ds[i-1], (32 + geff) * B);
        end
        if (dq.size() > 0)
            chk(ds[0] - send_cyc == 2 + dly * B, "R6 start delay", ds[0] - send_cyc, 2 + dly * B);
        chk(status == 3'b001 && data_rdy_n == 0, "R10 R13 emptied after frame", {status, data_rdy_n}, 4'b0010);
    endtask

    initial begin
        void'($urandom(32'h1A29));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(status == 3'b001 && !line_hi && !line_lo && !fifo_full && !data_rdy_n,
            "R1 reset state", {status, line_hi, line_lo, fifo_full, data_rdy_n}, 7'b0010000);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R4: send with empty buffer is ignored
        send();
        repeat (3) @(negedge clk);
        chk(status[2] == 0, "R4 send on empty ignored", status, 3'b001);

        // R2: high half without low half is ignored
        write_half(1, 16'hBEEF);
        chk(status[0] == 1 && data_rdy_n == 0, "R2 orphan high half", status, 3'b001);

        // Directed single frames: odd parity min gap, even parity larger gap + delay, clamped gap
        run_single(3, 0, 4, 0);
        run_single(2, 1, 10, 3);
        run_single(2, 0, 1, 0);     // R9 gap field below minimum clamps to 4

        // R3: fill the buffer, extra word dropped
        begin
            logic [31:0] words[$];
            dq.delete(); ds.delete();
            set_cfg(0, 0, 4, 0);
            for (int i = 0; i < DEPTH; i++) begin
                words.push_back($urandom());
                write_word(words[i]);
            end
            chk(fifo_full && status[1] && data_rdy_n, "R3 full flag", {fifo_full, status[1]}, 2'b11);
            write_word(32'hDEAD_0001);
            chk(fifo_full, "R3 full after extra write", fifo_full, 1);
            send();
            wait_idle();
            chk(dq.size() == DEPTH, "R3 extra word dropped", dq.size(), DEPTH);
            if (dq.size() == DEPTH)
                chk(dq[DEPTH-1] == exp_word(words[DEPTH-1], 0), "R3 last kept word", dq[DEPTH-1], exp_word(words[DEPTH-1], 0));
        end

        // R5: enable gating
        begin
            logic [31:0] w;
            dq.delete(); ds.delete();
            w = $urandom();
            tx_en_n = 1;
            write_word(w);
            send();
            repeat (100) @(negedge clk);
            chk(dq.size() == 0 && nb == 0 && status[2], "R5 held while disabled", dq.size(), 0);
            tx_en_n = 0;
            wait_idle();
            chk(dq.size() == 1 && dq[0] == exp_word(w, 0), "R5 sent after enable", dq.size() ? dq[0] : 0, exp_word(w, 0));
        end

        // R12: control write during busy is ignored
        begin
            dq.delete(); ds.delete();
            set_cfg(0, 0, 6, 0);
            write_word($urandom());
            write_word($urandom());
            send();
            repeat (10) @(negedge clk);
            set_cfg(0, 1, 20, 5);
            wait_idle();
            chk(dq.size() == 2 && ds[1] - ds[0] == 38 * B, "R12 cfg ignored while busy",
                dq.size() == 2 ? ds[1] - ds[0] : 0, 38 * B);
        end

        // R11: repeat mode with stop
        begin
            logic [31:0] w0, w1;
            dq.delete(); ds.delete();
            w0 = $urandom(); w1 = $urandom();
            set_cfg(1, 1, 4, 0);
            write_word(w0);
            write_word(w1);
            send();
            for (int i = 0; i < 20000 && dq.size() < 5; i++) @(negedge clk);
            @(negedge clk); stop_n = 0;
            @(negedge clk); stop_n = 1;
            wait_idle();
            chk(dq.size() == 5, "R11 words before stop", dq.size(), 5);
            for (int i = 0; i < dq.size(); i++)
                chk(dq[i] == exp_word((i % 2) ? w1 : w0, 1), "R11 repeat order", dq[i], exp_word((i % 2) ? w1 : w0, 1));
            chk(status == 3'b001, "R11 frame removed after stop", status, 3'b001);
        end

        // Random single frames
        for (int r = 0; r < 10; r++)
            run_single(1 + $urandom_range(3), $urandom_range(1), $urandom_range(15), $urandom_range(3));

        chk(bad_width == 0, "R7 pulse width", bad_width, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule